// File: doc/BRIEF.md
# Display Register Sampling Scheduler

This block keeps the shadow copies of a video controller's programmable settings that the renderer actually reads. The register file can change at any moment. Each group of settings is copied from the live values only when the event that governs that group occurs. Five single-cycle strobes mark those events: a plane mapping fetch slot, a pixel tick, a horizontal scroll fetch, the setting of the vertical blank flag, and the start of a two-cell column.

Vertical scroll data is staged. The value presented at a mapping fetch slot is held in a private stage register and reaches the renderer only at the next column boundary. A scroll value written while a line is being drawn therefore never changes columns that were already fetched. The horizontal scroll fetch happens once per line, so the block also uses it to update the line-length limit from the sampled width select. A width change can then only take effect on a line boundary.

Top module: `disp_reg_sampler`

## Requirements
- R1: A mapping strobe (`st_map`) loads the three plane base addresses, the field size and the alternate mode bit from the live inputs. They are visible one cycle later and do not change in any cycle without that strobe.
- R2: A pixel strobe (`st_pix`) loads palette depth, shade enable, display enable, extended mode, background colour, clock select and width select. They are visible one cycle later and hold otherwise.
- R3: The 2-bit horizontal scroll mode loads only on the horizontal scroll strobe (`st_hs`).
- R4: The tall-screen bit and the 2-bit interlace mode load only on the vertical blank strobe (`st_vbl`).
- R5: `vs_data` is captured into the stage on `st_map`. `vs_cur` takes the staged value one cycle after `st_col` and changes at no other time. A new `vs_data` never reaches `vs_cur` before the next column strobe.
- R6: When `st_map` and `st_col` fall on the same cycle, `vs_cur` takes the value staged before that cycle. The newly captured value appears only at the following column strobe.
- R7: On `st_hs`, `line_len` becomes 320 if the registered width select `sh_wide` is 1 and 256 if it is 0, using the value `sh_wide` holds in the strobe cycle. `line_len` does not change between horizontal scroll strobes.
- R8: A synchronous active-low reset zeroes every shadow output, `line_len` and the scroll stage. A column strobe after reset then yields `vs_cur` = 0.
- R9: Strobes that coincide act independently: each group updates exactly as it would under its own strobe alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_map | input | 1 | Plane mapping fetch slot strobe |
| st_pix | input | 1 | Pixel strobe |
| st_hs | input | 1 | Horizontal scroll fetch strobe (once per line) |
| st_vbl | input | 1 | Vertical blank flag set strobe |
| st_col | input | 1 | Two-cell column start strobe |
| lv_base_a | input | BASE_W | Live plane A mapping base |
| lv_base_b | input | BASE_W | Live plane B mapping base |
| lv_base_w | input | BASE_W | Live window mapping base |
| lv_field | input | FSZ_W | Live plane field size |
| lv_alt_mode | input | 1 | Live alternate display mode bit |
| lv_pal_deep | input | 1 | Live palette depth |
| lv_shade | input | 1 | Live shadow/highlight enable |
| lv_disp_en | input | 1 | Live display enable |
| lv_ext_mode | input | 1 | Live extended mode enable |
| lv_bg_color | input | BG_W | Live background colour index |
| lv_clk_sel | input | 1 | Live external dot clock select |
| lv_wide | input | 1 | Live wide line select |
| lv_hs_mode | input | 2 | Live horizontal scroll mode |
| lv_tall | input | 1 | Live tall screen select |
| lv_ilace | input | 2 | Live interlace mode |
| vs_data | input | VS_W | Vertical scroll value for the next column |
| sh_base_a | output | BASE_W | Sampled plane A base |
| sh_base_b | output | BASE_W | Sampled plane B base |
| sh_base_w | output | BASE_W | Sampled window base |
| sh_field | output | FSZ_W | Sampled field size |
| sh_alt_mode | output | 1 | Sampled alternate mode |
| sh_pal_deep | output | 1 | Sampled palette depth |
| sh_shade | output | 1 | Sampled shadow/highlight enable |
| sh_disp_en | output | 1 | Sampled display enable |
| sh_ext_mode | output | 1 | Sampled extended mode |
| sh_bg_color | output | BG_W | Sampled background colour |
| sh_clk_sel | output | 1 | Sampled clock select |
| sh_wide | output | 1 | Sampled width select |
| sh_hs_mode | output | 2 | Sampled horizontal scroll mode |
| sh_tall | output | 1 | Sampled tall screen select |
| sh_ilace | output | 2 | Sampled interlace mode |
| vs_cur | output | VS_W | Vertical scroll value for the current column |
| line_len | output | LEN_W | Pixels per line limit |

## Verification
A group whose enable is wired to the wrong strobe shows at its outputs as a value that moves one cycle after a foreign strobe, or that stays put after its own strobe. The check after each strobe therefore exposes it within two cycles. If the scroll stage is skipped or doubled, `vs_cur` shows a value one column early or one column late, and the next column strobe reveals it. A `line_len` fed from the live width input rather than the sampled one gives the wrong length as soon as the two differ at a horizontal scroll strobe.

// File: rtl/disp_reg_sampler.sv
module disp_reg_sampler #(
  parameter int BASE_W       = 6,
  parameter int FSZ_W        = 4,
  parameter int BG_W         = 6,
  parameter int VS_W         = 11,
  parameter int CELLS_NARROW = 32,
  parameter int CELLS_WIDE   = 40,
  parameter int CELL_PIX     = 8,
  localparam int LEN_W       = $clog2(CELLS_WIDE*CELL_PIX+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_map,
  input  logic              st_pix,
  input  logic              st_hs,
  input  logic              st_vbl,
  input  logic              st_col,
  input  logic [BASE_W-1:0] lv_base_a,
  input  logic [BASE_W-1:0] lv_base_b,
  input  logic [BASE_W-1:0] lv_base_w,
  input  logic [FSZ_W-1:0]  lv_field,
  input  logic              lv_alt_mode,
  input  logic              lv_pal_deep,
  input  logic              lv_shade,
  input  logic              lv_disp_en,
  input  logic              lv_ext_mode,
  input  logic [BG_W-1:0]   lv_bg_color,
  input  logic              lv_clk_sel,
  input  logic              lv_wide,
  input  logic [1:0]        lv_hs_mode,
  input  logic              lv_tall,
  input  logic [1:0]        lv_ilace,
  input  logic [VS_W-1:0]   vs_data,
  output logic [BASE_W-1:0] sh_base_a,
  output logic [BASE_W-1:0] sh_base_b,
  output logic [BASE_W-1:0] sh_base_w,
  output logic [FSZ_W-1:0]  sh_field,
  output logic              sh_alt_mode,
  output logic              sh_pal_deep,
  output logic              sh_shade,
  output logic              sh_disp_en,
  output logic              sh_ext_mode,
  output logic [BG_W-1:0]   sh_bg_color,
  output logic              sh_clk_sel,
  output logic              sh_wide,
  output logic [1:0]        sh_hs_mode,
  output logic              sh_tall,
  output logic [1:0]        sh_ilace,
  output logic [VS_W-1:0]   vs_cur,
  output logic [LEN_W-1:0]  line_len
);

  localparam logic [LEN_W-1:0] LEN_NARROW = LEN_W'(CELLS_NARROW*CELL_PIX);
  localparam logic [LEN_W-1:0] LEN_WIDE   = LEN_W'(CELLS_WIDE*CELL_PIX);

  logic [VS_W-1:0]  vs_stage;
  logic [LEN_W-1:0] len_next;

  assign len_next = sh_wide ? LEN_WIDE : LEN_NARROW;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_base_a   <= '0;
      sh_base_b   <= '0;
      sh_base_w   <= '0;
      sh_field    <= '0;
      sh_alt_mode <= 1'b0;
    end else if (st_map) begin
      sh_base_a   <= lv_base_a;
      sh_base_b   <= lv_base_b;
      sh_base_w   <= lv_base_w;
      sh_field    <= lv_field;
      sh_alt_mode <= lv_alt_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_pal_deep <= 1'b0;
      sh_shade    <= 1'b0;
      sh_disp_en  <= 1'b0;
      sh_ext_mode <= 1'b0;
      sh_bg_color <= '0;
      sh_clk_sel  <= 1'b0;
      sh_wide     <= 1'b0;
    end else if (st_pix) begin
      sh_pal_deep <= lv_pal_deep;
      sh_shade    <= lv_shade;
      sh_disp_en  <= lv_disp_en;
      sh_ext_mode <= lv_ext_mode;
      sh_bg_color <= lv_bg_color;
      sh_clk_sel  <= lv_clk_sel;
      sh_wide     <= lv_wide;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_hs_mode <= '0;
      line_len   <= '0;
    end else if (st_hs) begin
      sh_hs_mode <= lv_hs_mode;
      line_len   <= len_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_tall  <= 1'b0;
      sh_ilace <= '0;
    end else if (st_vbl) begin
      sh_tall  <= lv_tall;
      sh_ilace <= lv_ilace;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_stage <= '0;
      vs_cur   <= '0;
    end else begin
      if (st_map) vs_stage <= vs_data;
      if (st_col) vs_cur   <= vs_stage;
    end
  end

endmodule

// File: rtl/disp_reg_sampler_chk.sv
module disp_reg_sampler_chk #(
  parameter int BASE_W       = 6,
  parameter int FSZ_W        = 4,
  parameter int BG_W         = 6,
  parameter int VS_W         = 11,
  parameter int CELLS_NARROW = 32,
  parameter int CELLS_WIDE   = 40,
  parameter int CELL_PIX     = 8,
  localparam int LEN_W       = $clog2(CELLS_WIDE*CELL_PIX+1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_map,
  input logic              st_pix,
  input logic              st_hs,
  input logic              st_vbl,
  input logic              st_col,
  input logic [BASE_W-1:0] lv_base_a,
  input logic [BG_W-1:0]   lv_bg_color,
  input logic [1:0]        lv_hs_mode,
  input logic [1:0]        lv_ilace,
  input logic [BASE_W-1:0] sh_base_a,
  input logic [FSZ_W-1:0]  sh_field,
  input logic [BG_W-1:0]   sh_bg_color,
  input logic              sh_wide,
  input logic [1:0]        sh_hs_mode,
  input logic              sh_tall,
  input logic [1:0]        sh_ilace,
  input logic [VS_W-1:0]   vs_cur,
  input logic [LEN_W-1:0]  line_len
);

  p_map_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_map |=> sh_base_a == $past(lv_base_a));
  p_map_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !st_map |=> $stable(sh_base_a) && $stable(sh_field));
  p_pix_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_pix |=> sh_bg_color == $past(lv_bg_color));
  p_hs_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_hs |=> sh_hs_mode == $past(lv_hs_mode));
  p_hs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !st_hs |=> $stable(sh_hs_mode));
  p_vbl_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_vbl |=> sh_ilace == $past(lv_ilace));
  p_vbl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !st_vbl |=> $stable(sh_tall) && $stable(sh_ilace));
  p_vs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !st_col |=> $stable(vs_cur));
  p_len_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_hs |=> line_len == ($past(sh_wide) ? LEN_W'(CELLS_WIDE*CELL_PIX)
                                          : LEN_W'(CELLS_NARROW*CELL_PIX)));
  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !st_hs |=> $stable(line_len));

endmodule

bind disp_reg_sampler disp_reg_sampler_chk #(
  .BASE_W(BASE_W), .FSZ_W(FSZ_W), .BG_W(BG_W), .VS_W(VS_W),
  .CELLS_NARROW(CELLS_NARROW), .CELLS_WIDE(CELLS_WIDE), .CELL_PIX(CELL_PIX)
) u_chk (.*);

// File: tb/disp_reg_sampler_bench.sv
`timescale 1ns/1ps
module disp_reg_sampler_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic st_map = 0, st_pix = 0, st_hs = 0, st_vbl = 0, st_col = 0;
  logic [7:0] pat = '0;

  logic [5:0] sh_base_a, sh_base_b, sh_base_w, sh_bg_color;
  logic [3:0] sh_field;
  logic sh_alt_mode, sh_pal_deep, sh_shade, sh_disp_en, sh_ext_mode, sh_clk_sel, sh_wide, sh_tall;
  logic [1:0] sh_hs_mode, sh_ilace;
  logic [10:0] vs_cur;
  logic [8:0] line_len;

  disp_reg_sampler u_disp_reg_sampler (
    .clk(clk), .rst_n(rst_n),
    .st_map(st_map), .st_pix(st_pix), .st_hs(st_hs), .st_vbl(st_vbl), .st_col(st_col),
    .lv_base_a(pat[5:0]), .lv_base_b(~pat[5:0]), .lv_base_w({pat[2:0], pat[5:3]}),
    .lv_field(pat[7:4]), .lv_alt_mode(pat[0]),
    .lv_pal_deep(pat[1]), .lv_shade(pat[2]), .lv_disp_en(pat[3]), .lv_ext_mode(pat[4]),
    .lv_bg_color(pat[7:2]), .lv_clk_sel(pat[5]), .lv_wide(pat[6]),
    .lv_hs_mode(pat[1:0]), .lv_tall(pat[7]), .lv_ilace(pat[3:2]),
    .vs_data({3'b101, pat}),
    .sh_base_a(sh_base_a), .sh_base_b(sh_base_b), .sh_base_w(sh_base_w),
    .sh_field(sh_field), .sh_alt_mode(sh_alt_mode),
    .sh_pal_deep(sh_pal_deep), .sh_shade(sh_shade), .sh_disp_en(sh_disp_en),
    .sh_ext_mode(sh_ext_mode), .sh_bg_color(sh_bg_color), .sh_clk_sel(sh_clk_sel),
    .sh_wide(sh_wide), .sh_hs_mode(sh_hs_mode), .sh_tall(sh_tall), .sh_ilace(sh_ilace),
    .vs_cur(vs_cur), .line_len(line_len)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [22:0] e_map;
  logic [11:0] e_pix;
  logic [1:0]  e_hs;
  logic [2:0]  e_vbl;
  logic [10:0] e_stage, e_cur;
  logic [8:0]  e_len;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    e_map = '0; e_pix = '0; e_hs = '0; e_vbl = '0; e_stage = '0; e_cur = '0; e_len = '0;
  endtask

  task automatic compare_all(input string req);
    check(req == "" ? "R1" : req, "map group",
      32'({sh_base_a, sh_base_b, sh_base_w, sh_field, sh_alt_mode}), 32'(e_map));
    check(req == "" ? "R2" : req, "pixel group",
      32'({sh_pal_deep, sh_shade, sh_disp_en, sh_ext_mode, sh_bg_color, sh_clk_sel, sh_wide}), 32'(e_pix));
    check(req == "" ? "R3" : req, "hscroll mode", 32'(sh_hs_mode), 32'(e_hs));
    check(req == "" ? "R4" : req, "frame group", 32'({sh_tall, sh_ilace}), 32'(e_vbl));
    check(req == "" ? "R5" : req, "vs_cur", 32'(vs_cur), 32'(e_cur));
    check(req == "" ? "R7" : req, "line_len", 32'(line_len), 32'(e_len));
  endtask

  // strobes order {map, pix, hs, vbl, col}; R9 covered by multi-strobe rows
  task automatic step(input logic [4:0] s, input logic [7:0] p, input string req);
    @(negedge clk);
    pat = p;
    {st_map, st_pix, st_hs, st_vbl, st_col} = s;
    if (s[2]) e_len = e_pix[0] ? 9'd320 : 9'd256;
    if (s[0]) e_cur = e_stage;
    if (s[4]) begin
      e_map = {p[5:0], ~p[5:0], p[2:0], p[5:3], p[7:4], p[0]};
      e_stage = {3'b101, p};
    end
    if (s[3]) e_pix = {p[1], p[2], p[3], p[4], p[7:2], p[5], p[6]};
    if (s[2]) e_hs = p[1:0];
    if (s[1]) e_vbl = {p[7], p[3:2]};
    @(negedge clk);
    {st_map, st_pix, st_hs, st_vbl, st_col} = '0;
    compare_all(req);
  endtask

  localparam logic [12:0] VEC [20] = '{
    {5'b10000, 8'h3C}, {5'b01000, 8'h5A}, {5'b00100, 8'hC3}, {5'b00010, 8'h8E},
    {5'b00001, 8'h11}, {5'b00000, 8'hFF}, {5'b11111, 8'h47}, {5'b01000, 8'hE6},
    {5'b00100, 8'h02}, {5'b01000, 8'h00}, {5'b00000, 8'h99}, {5'b00100, 8'h40},
    {5'b10001, 8'hA5}, {5'b00001, 8'h0F}, {5'b10000, 8'h77}, {5'b00001, 8'h33},
    {5'b01100, 8'h68}, {5'b00110, 8'hB1}, {5'b10101, 8'h2D}, {5'b00000, 8'hD4}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R8");
    rst_n = 1'b1;

    for (int i = 0; i < 20; i++) begin
      logic [12:0] v;
      v = VEC[i];
      step(v[12:8], v[7:0], "");
    end

    // R6: same-cycle capture and column advance
    step(5'b10000, 8'h21, "R5");
    step(5'b10001, 8'h84, "R6");
    check("R6", "vs old stage", 32'(vs_cur), 32'({3'b101, 8'h21}));
    step(5'b00001, 8'h00, "R6");
    check("R6", "vs new stage", 32'(vs_cur), 32'({3'b101, 8'h84}));

    // R7: width change without hscroll strobe leaves line_len
    step(5'b01000, 8'h40, "R7");
    step(5'b00100, 8'h00, "R7");
    check("R7", "wide len", 32'(line_len), 32'd320);
    step(5'b01000, 8'h00, "R7");
    check("R7", "len held", 32'(line_len), 32'd320);

    // R8: reset mid-run clears all, including stage
    step(5'b11111, 8'hFF, "R9");
    step(5'b10000, 8'h5D, "R9");
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    compare_all("R8");
    rst_n = 1'b1;
    step(5'b00001, 8'h66, "R8");
    check("R8", "stage cleared", 32'(vs_cur), 32'd0);

    finish_run();
  end
endmodule